// File: doc/BRIEF.md
# Dual-Personality Host Bus Slave with Buffered DMA Requests

This block is the memory-mapped face of a crypto coprocessor on a 32-bit processor bus. A host reaches it through a 12-bit word address, an active-low chip select and a read/write line. A strap input picks one of two bus personalities. With the strap low, each access starts with a transfer-start strobe and ends with an active-low acknowledge. With the strap high, each beat is marked by an active-low data-valid and the shared handshake pin becomes an active-high wait indicator. In that personality, consecutive beats under an active-low burst marker step through consecutive word addresses.

The address space has eight regions of 512 words each. Region 0 holds the buffer control, count and request-routing registers. Region 1 is the write window into a 128-word input buffer. Region 2 is the read window out of a 128-word output buffer. Regions 3 to 7 drive one-hot selects towards the execution units that sit behind the interface. The engines drain the input buffer and fill the output buffer through a simple pop/push port. Words passing through either buffer window are byte-reversed when the endian input is high.

Two DMA request lines can each be routed to either buffer. A line routed to the input buffer asks for more data while there is enough free space. A line routed to the output buffer asks for a drain while enough words are stored.

Top module: `hostbus_fifo_slave`

The data bus is split into `wdata_i`, `rdata_o` and the drive enable `rdata_oe_o`. A pad ring joins them into the bidirectional pins.

## Requirements
- R1: Reset is asynchronous, active low, and released through a two-stage synchronizer. Reset empties both buffers and zeroes both counts, both control registers and the routing register. While reset holds and in the two cycles after it releases, both request lines are low. In strap-low mode the handshake pin idles high.
- R2: With the strap low, a cycle begins at a clock edge that sees chip select low and the start strobe low. At that edge the access takes effect. The handshake pin is low for exactly the following clock cycle and high again after it.
- R3: With the strap low, the data-valid input has no effect. An access with chip select and data-valid low but the start strobe high neither changes state nor acknowledges.
- R4: With the strap high, a beat takes effect at an edge that sees chip select low, data-valid low and the handshake pin low. The pin (wait) is high, and the beat is held off, while the access is a write to region 1 with the input buffer full or a read from region 2 with the output buffer empty.
- R5: With the strap high, a beat accepted with the burst marker low makes the next beat use the word address one above the current one, whatever the address lines show. Raising the burst marker ends this stepping.
- R6: While chip select is low and the word address falls in region 3+k (address bits 11:9), execution-unit select bit k is high. At most one select bit is high at any time, and none is high outside regions 3 to 7 or while chip select is high.
- R7: With the endian input high, a word written to region 1 enters the input buffer byte-reversed, and a word read from region 2 leaves byte-reversed. With the endian input low, words pass unchanged. Register accesses are never reversed.
- R8: Register offsets 2 and 3 of region 0 read the input and output buffer word counts in bits 7:0. A count never exceeds 128.
- R9: Register offsets 0 (input) and 1 (output) hold an enable in bit 31 and a threshold in bits 7:0. Offset 4 bit k routes request line k to the input buffer (0) or the output buffer (1). A line routed to the input buffer is high, one cycle after the count changes, exactly when that buffer is enabled and its free space (128 minus count) is at or above its threshold.
- R10: A request line routed to the output buffer is high, one cycle after the count changes, exactly when that buffer is enabled and its stored count is at or above its threshold.
- R11: With the strap low, a write to a full input buffer is acknowledged but dropped. A read from an empty output buffer is acknowledged, returns zero and leaves the count at zero.
- R12: Read data is presented on `rdata_o` with `rdata_oe_o` high in the cycle after an accepted read. `rdata_oe_o` is low after accepted writes and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Bus personality strap: 0 start/acknowledge, 1 data-valid/wait burst |
| big_end_i | input | 1 | 1 reverses byte lanes on buffer windows |
| cs_n_i | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 12 | Word address |
| start_n_i | input | 1 | Transfer-start strobe, active low (strap low only) |
| dval_n_i | input | 1 | Beat data-valid, active low (strap high only) |
| burst_n_i | input | 1 | Burst marker, active low (strap high only) |
| wdata_i | input | 32 | Write data from host |
| rdata_o | output | 32 | Read data to host |
| rdata_oe_o | output | 1 | Read data drive enable |
| tw_o | output | 1 | Acknowledge (active low, strap low) or wait (active high, strap high) |
| eu_sel_o | output | 5 | One-hot execution-unit selects for regions 3 to 7 |
| dreq_o | output | 2 | DMA request lines, active high |
| in_pop_i | input | 1 | Engine pops the input buffer head |
| in_head_o | output | 32 | Input buffer head word |
| out_push_i | input | 1 | Engine pushes a word into the output buffer |
| out_wdata_i | input | 32 | Word pushed by the engine |

## Verification
The handshake is tried in both personalities. Register write-then-read pairs show that the access takes effect at the start edge. A start-less access with data-valid low shows that the strap-low path ignores data-valid. A write into a full buffer shows the wait stalling a beat and then releasing it once the engine pops a word. Asymmetric byte patterns such as 11223344 and AABBCCDD go through both windows in each endian setting, and they tell a lane swap apart from a plain or partial copy. Thresholds are placed one word either side of the live count, with each request line routed to each buffer and with the enable cleared. This catches comparisons that are off by one, inverted routing and free space mixed up with stored count. A two-beat burst aimed at offset 0 separates real address stepping from a reuse of the address lines.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [2:0] {
    RG_REGS = 3'd0,
    RG_INF  = 3'd1,
    RG_OUTF = 3'd2
  } region_e;

  localparam logic [2:0] OFS_IN_CTL  = 3'd0;
  localparam logic [2:0] OFS_OUT_CTL = 3'd1;
  localparam logic [2:0] OFS_IN_CNT  = 3'd2;
  localparam logic [2:0] OFS_OUT_CNT = 3'd3;
  localparam logic [2:0] OFS_ROUTE   = 3'd4;
  localparam int         FIRST_EU    = 3;
endpackage

// File: rtl/hbs_fifo.sv
module hbs_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rp_q];
  assign count_o = cnt_q;

  always_comb begin
    wp_d  = do_push ? wp_q + 1'b1 : wp_q;
    rp_d  = do_pop  ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/hbs_decode.sv
module hbs_decode #(
  parameter int AW  = 12,
  parameter int NEU = 5
) (
  input  logic          cs_act_i,
  input  logic [AW-1:0] addr_i,
  output logic [2:0]    region_o,
  output logic [2:0]    offset_o,
  output logic [NEU-1:0] eu_sel_o
);
  import hbs_pkg::*;
  assign region_o = addr_i[AW-1 -: 3];
  assign offset_o = addr_i[2:0];

  for (genvar k = 0; k < NEU; k++) begin : g_sel
    assign eu_sel_o[k] = cs_act_i && (region_o == 3'(FIRST_EU + k));
  end
endmodule

// File: rtl/hbs_dreq.sv
module hbs_dreq #(
  parameter int DEPTH = 128,
  parameter int NREQ  = 2,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   in_cnt_i,
  input  logic [CW-1:0]   out_cnt_i,
  input  logic            in_en_i,
  input  logic [CW-1:0]   in_thr_i,
  input  logic            out_en_i,
  input  logic [CW-1:0]   out_thr_i,
  input  logic [NREQ-1:0] route_i,
  output logic [NREQ-1:0] dreq_o
);
  logic [CW-1:0]   free_w;
  logic            in_hit, out_hit;
  logic [NREQ-1:0] req_d, req_q;

  assign free_w  = CW'(DEPTH) - in_cnt_i;
  assign in_hit  = in_en_i && (free_w >= in_thr_i);
  assign out_hit = out_en_i && (out_cnt_i >= out_thr_i);

  for (genvar k = 0; k < NREQ; k++) begin : g_req
    assign req_d[k] = route_i[k] ? out_hit : in_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
  assign dreq_o = req_q;
endmodule

// File: rtl/hostbus_fifo_slave.sv
module hostbus_fifo_slave #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  parameter int NEU   = 5,
  parameter int NREQ  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic            big_end_i,
  input  logic            cs_n_i,
  input  logic            rw_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            start_n_i,
  input  logic            dval_n_i,
  input  logic            burst_n_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            rdata_oe_o,
  output logic            tw_o,
  output logic [NEU-1:0]  eu_sel_o,
  output logic [NREQ-1:0] dreq_o,
  input  logic            in_pop_i,
  output logic [DW-1:0]   in_head_o,
  input  logic            out_push_i,
  input  logic [DW-1:0]   out_wdata_i
);
  import hbs_pkg::*;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int NB = DW / 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // state
  logic            in_en_q, out_en_q, in_en_d, out_en_d;
  logic [CW-1:0]   in_thr_q, out_thr_q, in_thr_d, out_thr_d;
  logic [NREQ-1:0] route_q, route_d;
  logic            ack_q, ack_d, oe_q, oe_d;
  logic [DW-1:0]   rdat_q, rdat_d;
  logic            bst_q, bst_d;
  logic [AW-1:0]   bst_addr_q, bst_addr_d;

  // buffers
  logic [CW-1:0] in_cnt, out_cnt;
  logic          in_full, in_empty, out_full, out_empty;
  logic [DW-1:0] out_head, in_wdata, out_rd_lane;
  logic          in_push, out_pop;

  // decode
  logic [AW-1:0] eff_addr;
  logic [2:0]    region, offset;
  logic          cs_act, wait_w, accept;

  assign cs_act   = !cs_n_i;
  assign eff_addr = bst_q ? bst_addr_q : addr_i;

  hbs_decode #(.AW(AW), .NEU(NEU)) u_dec (
    .cs_act_i(cs_act), .addr_i(eff_addr),
    .region_o(region), .offset_o(offset), .eu_sel_o(eu_sel_o)
  );

  // byte-lane reversal on the buffer windows
  logic [DW-1:0] wr_swap, rd_swap;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign wr_swap[8*b +: 8] = wdata_i[8*(NB-1-b) +: 8];
    assign rd_swap[8*b +: 8] = out_head[8*(NB-1-b) +: 8];
  end
  assign in_wdata    = big_end_i ? wr_swap : wdata_i;
  assign out_rd_lane = big_end_i ? rd_swap : out_head;

  // handshake
  assign wait_w = mode_i && cs_act &&
                  (((region == RG_INF)  && !rw_i && in_full) ||
                   ((region == RG_OUTF) &&  rw_i && out_empty));
  assign accept = cs_act && (mode_i ? (!dval_n_i && !wait_w) : !start_n_i);
  assign in_push = accept && !rw_i && (region == RG_INF);
  assign out_pop = accept &&  rw_i && (region == RG_OUTF);

  always_comb begin
    in_en_d = in_en_q;   in_thr_d = in_thr_q;
    out_en_d = out_en_q; out_thr_d = out_thr_q;
    route_d = route_q;
    if (accept && !rw_i && (region == RG_REGS)) begin
      case (offset)
        OFS_IN_CTL:  begin in_en_d  = wdata_i[DW-1]; in_thr_d  = wdata_i[CW-1:0]; end
        OFS_OUT_CTL: begin out_en_d = wdata_i[DW-1]; out_thr_d = wdata_i[CW-1:0]; end
        OFS_ROUTE:   route_d = wdata_i[NREQ-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdat_d = '0;
    if (region == RG_REGS) begin
      case (offset)
        OFS_IN_CTL:  rdat_d = {in_en_q,  {(DW-1-CW){1'b0}}, in_thr_q};
        OFS_OUT_CTL: rdat_d = {out_en_q, {(DW-1-CW){1'b0}}, out_thr_q};
        OFS_IN_CNT:  rdat_d = {{(DW-CW){1'b0}}, in_cnt};
        OFS_OUT_CNT: rdat_d = {{(DW-CW){1'b0}}, out_cnt};
        OFS_ROUTE:   rdat_d = {{(DW-NREQ){1'b0}}, route_q};
        default:     rdat_d = '0;
      endcase
    end else if (region == RG_OUTF && !out_empty) begin
      rdat_d = out_rd_lane;
    end
    if (!(accept && rw_i)) rdat_d = rdat_q;
    oe_d  = accept && rw_i;
    ack_d = accept && !mode_i;
    bst_addr_d = bst_addr_q;
    if (!mode_i) bst_d = 1'b0;
    else if (accept) begin
      bst_d = !burst_n_i;
      if (!burst_n_i) bst_addr_d = eff_addr + 1'b1;
    end else bst_d = bst_q && !burst_n_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      in_en_q <= 1'b0;  in_thr_q <= '0;
      out_en_q <= 1'b0; out_thr_q <= '0;
      route_q <= '0;    ack_q <= 1'b0;
      oe_q <= 1'b0;     rdat_q <= '0;
      bst_q <= 1'b0;    bst_addr_q <= '0;
    end else begin
      in_en_q <= in_en_d;   in_thr_q <= in_thr_d;
      out_en_q <= out_en_d; out_thr_q <= out_thr_d;
      route_q <= route_d;   ack_q <= ack_d;
      oe_q <= oe_d;         rdat_q <= rdat_d;
      bst_q <= bst_d;       bst_addr_q <= bst_addr_d;
    end
  end

  assign tw_o       = mode_i ? wait_w : !ack_q;
  assign rdata_o    = rdat_q;
  assign rdata_oe_o = oe_q;

  hbs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_inf (
    .clk(clk), .rst_n(srst_n), .push_i(in_push), .pop_i(in_pop_i),
    .wdata_i(in_wdata), .rdata_o(in_head_o), .count_o(in_cnt),
    .full_o(in_full), .empty_o(in_empty)
  );

  hbs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_outf (
    .clk(clk), .rst_n(srst_n), .push_i(out_push_i), .pop_i(out_pop),
    .wdata_i(out_wdata_i), .rdata_o(out_head), .count_o(out_cnt),
    .full_o(out_full), .empty_o(out_empty)
  );

  hbs_dreq #(.DEPTH(DEPTH), .NREQ(NREQ)) u_req (
    .clk(clk), .rst_n(srst_n), .in_cnt_i(in_cnt), .out_cnt_i(out_cnt),
    .in_en_i(in_en_q), .in_thr_i(in_thr_q), .out_en_i(out_en_q),
    .out_thr_i(out_thr_q), .route_i(route_q), .dreq_o(dreq_o)
  );
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
  parameter int DEPTH = 128,
  parameter int NEU   = 5,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_i,
  input logic           start_n_i,
  input logic           tw_o,
  input logic           rdata_oe_o,
  input logic [NEU-1:0] eu_sel_o,
  input logic [CW-1:0]  in_cnt,
  input logic [CW-1:0]  out_cnt
);
  // R2: acknowledge lasts one cycle
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !tw_o) |=> (mode_i || tw_o));

  // R3: no start strobe, no acknowledge
  p_no_start_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && start_n_i) |=> (mode_i || tw_o));

  // R6: selects are one-hot or idle
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eu_sel_o));

  // R8: counts bounded by depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH)));

  // R12: read data driven only alongside the acknowledge
  p_oe_with_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && rdata_oe_o) |-> !tw_o);
endmodule

bind hostbus_fifo_slave hbs_checker #(.DEPTH(DEPTH), .NEU(NEU)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_n_i(start_n_i),
  .tw_o(tw_o), .rdata_oe_o(rdata_oe_o), .eu_sel_o(eu_sel_o),
  .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/sim_hostbus_fifo_slave.sv
`timescale 1ns/1ps
module sim_hostbus_fifo_slave;
  localparam real TCK = 4.0;
  localparam logic [11:0] A_INCTL = 12'h000, A_OUTCTL = 12'h001,
    A_INCNT = 12'h002, A_OUTCNT = 12'h003, A_ROUTE = 12'h004,
    A_INF = 12'h200, A_OUTF = 12'h400;

  logic clk = 1'b0, rst_n, mode, bige, cs_n, rw, start_n, dval_n, burst_n;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, in_head, out_wdata, q;
  logic oe, tw, in_pop, out_push;
  logic [4:0] eu_sel;
  logic [1:0] dreq;
  int total = 0, fails = 0;

  always #(TCK/2) clk = ~clk;

  hostbus_fifo_slave u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .big_end_i(bige), .cs_n_i(cs_n),
    .rw_i(rw), .addr_i(addr), .start_n_i(start_n), .dval_n_i(dval_n),
    .burst_n_i(burst_n), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe),
    .tw_o(tw), .eu_sel_o(eu_sel), .dreq_o(dreq), .in_pop_i(in_pop),
    .in_head_o(in_head), .out_push_i(out_push), .out_wdata_i(out_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m0(input bit rd, input logic [11:0] a, input logic [31:0] d, output logic [31:0] r);
    cs_n = 0; start_n = 0; rw = rd; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1; start_n = 1;
    chk(tw == 1'b0, "R2 ack low", {31'b0, tw}, 0);
    chk(oe == rd, "R12 oe", {31'b0, oe}, {31'b0, rd});
    r = rdata;
    @(negedge clk);
    chk(tw == 1'b1, "R2 ack released", {31'b0, tw}, 1);
  endtask

  task automatic m1_beat(input bit rd, input logic [11:0] a, input logic [31:0] d, input bit bst, output logic [31:0] r);
    cs_n = 0; dval_n = 0; burst_n = !bst; rw = rd; addr = a; wdata = d;
    @(negedge clk);
    r = rdata;
  endtask

  task automatic m1_idle();
    cs_n = 1; dval_n = 1; burst_n = 1;
    @(negedge clk);
  endtask

  task automatic eng_pop();
    in_pop = 1; @(negedge clk); in_pop = 0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    out_push = 1; out_wdata = d; @(negedge clk); out_push = 0;
  endtask

  task automatic drain_in();
    in_pop = 1; repeat (130) @(negedge clk); in_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk(tw == 1, "R1 idle handshake", {31'b0, tw}, 1);
    chk(dreq == 0, "R1 dreq", {30'b0, dreq}, 0);
    m0(1, A_INCNT, 0, r);  chk(r == 0, "R1 in count", r, 0);
    m0(1, A_ROUTE, 0, r);  chk(r == 0, "R1 route", r, 0);
    m0(1, A_OUTCTL, 0, r); chk(r == 0, "R1 out ctl", r, 0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    m0(0, A_INCTL, 32'h8000_0010, r);
    m0(1, A_INCTL, 0, r);
    chk(r == 32'h8000_0010, "R2 reg readback", r, 32'h8000_0010);
    chk(oe == 0, "R12 oe idle", {31'b0, oe}, 0);
    m0(0, A_INCTL, 32'h0000_0000, r);
  endtask

  task automatic t_dval_ignored();
    logic [31:0] r;
    cs_n = 0; dval_n = 0; start_n = 1; rw = 0; addr = A_INCTL; wdata = 32'h8000_0077;
    @(negedge clk);
    chk(tw == 1, "R3 no ack", {31'b0, tw}, 1);
    cs_n = 1; dval_n = 1;
    @(negedge clk);
    m0(1, A_INCTL, 0, r);
    chk(r == 0, "R3 reg untouched", r, 0);
  endtask

  task automatic t_decode();
    for (int k = 0; k < 5; k++) begin
      cs_n = 0; start_n = 1; addr = 12'((k + 3) << 9); #1;
      chk(eu_sel == 5'(1 << k), "R6 select", {27'b0, eu_sel}, 32'(1 << k));
      @(negedge clk);
    end
    addr = A_INF; #1;
    chk(eu_sel == 0, "R6 buffer region", {27'b0, eu_sel}, 0);
    cs_n = 1; addr = 12'hE00; #1;
    chk(eu_sel == 0, "R6 deselected", {27'b0, eu_sel}, 0);
    @(negedge clk);
  endtask

  task automatic t_endian();
    logic [31:0] r;
    bige = 0; m0(0, A_INF, 32'h1122_3344, r);
    bige = 1; m0(0, A_INF, 32'hAABB_CCDD, r);
    bige = 0; m0(0, A_INF, 32'h0000_0005, r);
    m0(1, A_INCNT, 0, r); chk(r == 3, "R8 in count", r, 3);
    chk(in_head == 32'h1122_3344, "R7 little write", in_head, 32'h1122_3344);
    eng_pop();
    chk(in_head == 32'hDDCC_BBAA, "R7 big write", in_head, 32'hDDCC_BBAA);
    eng_push(32'h0102_0304);
    eng_push(32'h0506_0708);
    m0(1, A_OUTCNT, 0, r); chk(r == 2, "R8 out count", r, 2);
    bige = 1; m0(1, A_OUTF, 0, r);
    chk(r == 32'h0403_0201, "R7 big read", r, 32'h0403_0201);
    bige = 0; m0(1, A_OUTF, 0, r);
    chk(r == 32'h0506_0708, "R7 little read", r, 32'h0506_0708);
    bige = 1; m0(1, A_INCNT, 0, r);
    chk(r == 2, "R7 regs not reversed", r, 2);
    bige = 0;
  endtask

  task automatic t_dreq_in();
    logic [31:0] r;
    drain_in();
    m0(0, A_ROUTE, 0, r);
    m0(0, A_INCTL, 32'h8000_007E, r);
    chk(dreq == 2'b11, "R9 free 128 thr 126", {30'b0, dreq}, 3);
    m0(0, A_INF, 1, r); m0(0, A_INF, 2, r); m0(0, A_INF, 3, r);
    chk(dreq == 2'b00, "R9 free 125 thr 126", {30'b0, dreq}, 0);
    eng_pop(); @(negedge clk);
    chk(dreq == 2'b11, "R9 free 126 thr 126", {30'b0, dreq}, 3);
    m0(0, A_INCTL, 32'h0000_007E, r);
    chk(dreq == 2'b00, "R9 disabled", {30'b0, dreq}, 0);
  endtask

  task automatic t_dreq_out();
    logic [31:0] r;
    m0(0, A_ROUTE, 32'h2, r);
    m0(0, A_OUTCTL, 32'h8000_0002, r);
    eng_push(32'hA); @(negedge clk);
    chk(dreq == 2'b00, "R10 count 1 thr 2", {30'b0, dreq}, 0);
    eng_push(32'hB); @(negedge clk);
    chk(dreq == 2'b10, "R10 count 2 thr 2", {30'b0, dreq}, 2);
    m0(1, A_OUTF, 0, r);
    chk(r == 32'hA, "R10 drain word", r, 32'hA);
    chk(dreq == 2'b00, "R10 count 1 after read", {30'b0, dreq}, 0);
    m0(1, A_OUTF, 0, r);
  endtask

  task automatic t_limits();
    logic [31:0] r;
    m0(1, A_OUTF, 0, r); chk(r == 0, "R11 empty read", r, 0);
    m0(1, A_OUTCNT, 0, r); chk(r == 0, "R11 empty count", r, 0);
    drain_in();
    for (int i = 0; i < 128; i++) m0(0, A_INF, 32'(i + 100), r);
    m0(0, A_INF, 32'hDEAD, r);
    m0(1, A_INCNT, 0, r); chk(r == 128, "R11 full count", r, 128);
    chk(in_head == 32'd100, "R11 head kept", in_head, 100);
  endtask

  task automatic t_wait();
    logic [31:0] r;
    mode = 1; @(negedge clk);
    chk(tw == 0, "R4 idle no wait", {31'b0, tw}, 0);
    cs_n = 0; dval_n = 0; burst_n = 1; rw = 0; addr = A_INF; wdata = 32'h55; #1;
    chk(tw == 1, "R4 wait on full", {31'b0, tw}, 1);
    @(negedge clk);
    chk(tw == 1, "R4 wait held", {31'b0, tw}, 1);
    in_pop = 1; @(negedge clk); in_pop = 0;
    chk(tw == 0, "R4 wait released", {31'b0, tw}, 0);
    @(negedge clk);
    m1_idle();
    m1_beat(1, A_INCNT, 0, 0, r); m1_idle();
    chk(r == 128, "R4 beat accepted after pop", r, 128);
    cs_n = 0; dval_n = 0; rw = 1; addr = A_OUTF; #1;
    chk(tw == 1, "R4 wait on empty read", {31'b0, tw}, 1);
    @(negedge clk);
    m1_idle();
  endtask

  task automatic t_burst();
    logic [31:0] r;
    m1_beat(0, A_INCTL, 32'h8000_0011, 1, r);
    m1_beat(0, A_INCTL, 32'h8000_0022, 1, r);
    m1_idle();
    m1_beat(1, A_INCTL, 0, 0, r);
    chk(r == 32'h8000_0011, "R5 first beat", r, 32'h8000_0011);
    chk(oe == 1, "R12 oe burst mode read", {31'b0, oe}, 1);
    m1_beat(1, A_OUTCTL, 0, 0, r); m1_idle();
    chk(r == 32'h8000_0022, "R5 stepped beat", r, 32'h8000_0022);
    mode = 0; @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; mode = 0; bige = 0; cs_n = 1; rw = 0; start_n = 1; dval_n = 1;
    burst_n = 1; addr = 0; wdata = 0; in_pop = 0; out_push = 0; out_wdata = 0;
    repeat (3) @(negedge clk);
    chk(dreq == 0, "R1 dreq in reset", {30'b0, dreq}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_dval_ignored();
    t_decode();
    t_endian();
    t_dreq_in();
    t_dreq_out();
    t_limits();
    t_wait();
    t_burst();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule